// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits beside the configuration registers of a PCI-to-PCI bridge. It reads the bridge's I/O and memory base/limit fields and turns them into address windows, each with a base, an inclusive span (size) and a valid flag. Windows follow the bridge granularity rules: 4 KB for I/O and 1 MB for memory. A window is recomputed only in the cycle after software writes the matching field group, which the block sees as an update strobe. A field pair that describes an empty range removes the window.

The I/O window sits in CPU address space at a configurable offset above its bus address. A lookup port takes a CPU address and a type flag and reports, in the same cycle, whether the address falls inside the window of that type. It also returns the bus address that goes downstream. Memory addresses pass through unchanged. I/O addresses are moved back from the CPU offset to the bus base.

Top module: `brwin_decoder`

## Requirements
- R1: After reset both windows are invalid, every window base, span and bus base output is zero, and no lookup hits.
- R2: When the I/O strobe is sampled, the I/O window is dropped if the full 8-bit I/O limit byte is below the full 8-bit I/O base byte, or if the 16-bit upper limit is below the 16-bit upper base. A dropped window has base 0, size 0 and valid 0, and its bus base output is also 0.
- R3: A valid I/O window has a bus base of (upper base << 16) | (base byte bits 7:4 << 12). Its CPU base is the CPU I/O offset plus that bus base, modulo 2^32.
- R4: A valid I/O window has a size of ((upper limit << 16) | (limit byte bits 7:4 << 12) | 0xFFF) minus the bus base.
- R5: When the memory strobe is sampled, the memory window is dropped (base 0, size 0, valid 0) if the 16-bit memory limit is below the 16-bit memory base.
- R6: A valid memory window has base = (memory base bits 15:4) << 20 and size = (((memory limit bits 15:4) << 20) | 0xFFFFF) minus that base.
- R7: Window outputs change only at the clock edge that samples their strobe, so the new values can be read one cycle after the strobe. Without a strobe the window holds even while its fields change. Each strobe affects only its own window.
- R8: With type flag 1 (I/O) or 0 (memory), the lookup hits only when the window of that type is valid and base <= address <= base + size. The result is combinational in the same cycle.
- R9: On a memory hit the translated address equals the lookup address. On an I/O hit it is address − CPU base + bus base. On a miss it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_base_lo | input | 8 | I/O base byte (bits 7:4 give address bits 15:12) |
| io_limit_lo | input | 8 | I/O limit byte (bits 7:4 give address bits 15:12) |
| io_base_hi | input | 16 | I/O base upper 16 address bits |
| io_limit_hi | input | 16 | I/O limit upper 16 address bits |
| io_upd | input | 1 | Recompute the I/O window |
| mem_base_f | input | 16 | Memory base field (bits 15:4 give address bits 31:20) |
| mem_limit_f | input | 16 | Memory limit field (bits 15:4 give address bits 31:20) |
| mem_upd | input | 1 | Recompute the memory window |
| io_cpu_ofs | input | 32 | CPU address of I/O bus address 0 |
| lk_addr | input | 32 | Lookup CPU address |
| lk_is_io | input | 1 | Lookup type: 1 = I/O, 0 = memory |
| io_win_base | output | 32 | I/O window CPU base |
| io_win_size | output | 32 | I/O window inclusive span |
| io_win_bus | output | 32 | I/O window bus base |
| io_win_valid | output | 1 | I/O window present |
| mem_win_base | output | 32 | Memory window base |
| mem_win_size | output | 32 | Memory window inclusive span |
| mem_win_valid | output | 1 | Memory window present |
| lk_hit | output | 1 | Lookup falls in the selected window |
| lk_xlat | output | 32 | Translated bus address, 0 on miss |

## Verification
Window descriptors come from one register stage. The bench raises a strobe at a falling edge and reads the window at the next falling edge, after the single rising edge that loads it. It also checks that the window has not moved while fields change with no strobe. Hit and translation are combinational from the registered windows. They are sampled 1 ns after the lookup inputs change, well away from any edge, and compared against a model that the bench updates on every strobe. Each window is probed at its first byte, its last byte, and one byte outside at each end.

// File: rtl/brwin_pkg.sv
package brwin_pkg;
  localparam int AW       = 32;
  localparam int IO_LO_W  = 8;
  localparam int IO_HI_W  = 16;
  localparam int MEM_W    = 16;
  localparam int IO_SH    = 12;
  localparam int MEM_SH   = 20;
  localparam int NWIN     = 2;
  localparam int WIN_IO   = 0;
  localparam int WIN_MEM  = 1;
  localparam logic [AW-1:0] IO_FILL  = AW'((1 << IO_SH) - 1);
  localparam logic [AW-1:0] MEM_FILL = AW'((1 << MEM_SH) - 1);

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] size;
    logic          valid;
  } win_t;

  function automatic logic io_empty(input logic [IO_LO_W-1:0] b, input logic [IO_LO_W-1:0] l,
                                    input logic [IO_HI_W-1:0] bh, input logic [IO_HI_W-1:0] lh);
    return (l < b) || (lh < bh);
  endfunction

  function automatic logic [AW-1:0] io_start(input logic [IO_LO_W-1:0] b, input logic [IO_HI_W-1:0] bh);
    return (AW'(bh) << 16) | (AW'(b[7:4]) << IO_SH);
  endfunction

  function automatic logic [AW-1:0] io_last(input logic [IO_LO_W-1:0] l, input logic [IO_HI_W-1:0] lh);
    return (AW'(lh) << 16) | (AW'(l[7:4]) << IO_SH) | IO_FILL;
  endfunction

  function automatic logic [AW-1:0] mem_start(input logic [MEM_W-1:0] b);
    return AW'(b[15:4]) << MEM_SH;
  endfunction

  function automatic logic [AW-1:0] mem_last(input logic [MEM_W-1:0] l);
    return (AW'(l[15:4]) << MEM_SH) | MEM_FILL;
  endfunction
endpackage

// File: rtl/brwin_io_win.sv
module brwin_io_win
  import brwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [IO_LO_W-1:0] base_lo,
  input  logic [IO_LO_W-1:0] limit_lo,
  input  logic [IO_HI_W-1:0] base_hi,
  input  logic [IO_HI_W-1:0] limit_hi,
  input  logic [AW-1:0]      cpu_ofs,
  output win_t               win,
  output logic [AW-1:0]      bus_base
);
  logic          drop_evt;
  logic          load_evt;
  logic [AW-1:0] nxt_bus;
  logic [AW-1:0] nxt_last;

  always_comb begin
    nxt_bus  = io_start(base_lo, base_hi);
    nxt_last = io_last(limit_lo, limit_hi);
    drop_evt = upd && io_empty(base_lo, limit_lo, base_hi, limit_hi);
    load_evt = upd && !drop_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win      <= '0;
      bus_base <= '0;
    end else if (drop_evt) begin
      win      <= '0;
      bus_base <= '0;
    end else if (load_evt) begin
      win.base  <= cpu_ofs + nxt_bus;
      win.size  <= nxt_last - nxt_bus;
      win.valid <= 1'b1;
      bus_base  <= nxt_bus;
    end
  end
endmodule

// File: rtl/brwin_mem_win.sv
module brwin_mem_win
  import brwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [MEM_W-1:0] base_f,
  input  logic [MEM_W-1:0] limit_f,
  output win_t             win
);
  logic          drop_evt;
  logic          load_evt;
  logic [AW-1:0] nxt_base;
  logic [AW-1:0] nxt_last;

  always_comb begin
    nxt_base = mem_start(base_f);
    nxt_last = mem_last(limit_f);
    drop_evt = upd && (limit_f < base_f);
    load_evt = upd && !drop_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0;
    end else if (drop_evt) begin
      win <= '0;
    end else if (load_evt) begin
      win.base  <= nxt_base;
      win.size  <= nxt_last - nxt_base;
      win.valid <= 1'b1;
    end
  end
endmodule

// File: rtl/brwin_hit.sv
module brwin_hit
  import brwin_pkg::*;
(
  input  win_t          win,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [AW-1:0] rel;
  always_comb begin
    rel = addr - win.base;
    hit = win.valid && (addr >= win.base) && (rel <= win.size);
  end
endmodule

// File: rtl/brwin_decoder.sv
module brwin_decoder
  import brwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IO_LO_W-1:0] io_base_lo,
  input  logic [IO_LO_W-1:0] io_limit_lo,
  input  logic [IO_HI_W-1:0] io_base_hi,
  input  logic [IO_HI_W-1:0] io_limit_hi,
  input  logic               io_upd,
  input  logic [MEM_W-1:0]   mem_base_f,
  input  logic [MEM_W-1:0]   mem_limit_f,
  input  logic               mem_upd,
  input  logic [AW-1:0]      io_cpu_ofs,
  input  logic [AW-1:0]      lk_addr,
  input  logic               lk_is_io,
  output logic [AW-1:0]      io_win_base,
  output logic [AW-1:0]      io_win_size,
  output logic [AW-1:0]      io_win_bus,
  output logic               io_win_valid,
  output logic [AW-1:0]      mem_win_base,
  output logic [AW-1:0]      mem_win_size,
  output logic               mem_win_valid,
  output logic               lk_hit,
  output logic [AW-1:0]      lk_xlat
);
  win_t          wins [NWIN];
  logic [NWIN-1:0] win_hit;
  logic [AW-1:0] io_bus_q;

  brwin_io_win u_io (
    .clk(clk), .rst_n(rst_n), .upd(io_upd),
    .base_lo(io_base_lo), .limit_lo(io_limit_lo),
    .base_hi(io_base_hi), .limit_hi(io_limit_hi),
    .cpu_ofs(io_cpu_ofs), .win(wins[WIN_IO]), .bus_base(io_bus_q)
  );

  brwin_mem_win u_mem (
    .clk(clk), .rst_n(rst_n), .upd(mem_upd),
    .base_f(mem_base_f), .limit_f(mem_limit_f), .win(wins[WIN_MEM])
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    brwin_hit u_hit (.win(wins[g]), .addr(lk_addr), .hit(win_hit[g]));
  end

  always_comb begin
    io_win_base   = wins[WIN_IO].base;
    io_win_size   = wins[WIN_IO].size;
    io_win_valid  = wins[WIN_IO].valid;
    io_win_bus    = io_bus_q;
    mem_win_base  = wins[WIN_MEM].base;
    mem_win_size  = wins[WIN_MEM].size;
    mem_win_valid = wins[WIN_MEM].valid;
    lk_hit  = lk_is_io ? win_hit[WIN_IO] : win_hit[WIN_MEM];
    lk_xlat = '0;
    if (lk_hit) begin
      if (lk_is_io) lk_xlat = lk_addr - wins[WIN_IO].base + io_bus_q;
      else          lk_xlat = lk_addr;
    end
  end
endmodule

// File: rtl/brwin_decoder_chk.sv
module brwin_decoder_chk
  import brwin_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [IO_LO_W-1:0] io_base_lo,
  input logic [IO_LO_W-1:0] io_limit_lo,
  input logic [IO_HI_W-1:0] io_base_hi,
  input logic [IO_HI_W-1:0] io_limit_hi,
  input logic               io_upd,
  input logic [MEM_W-1:0]   mem_base_f,
  input logic [MEM_W-1:0]   mem_limit_f,
  input logic               mem_upd,
  input logic [AW-1:0]      lk_addr,
  input logic               lk_is_io,
  input logic [AW-1:0]      io_win_base,
  input logic [AW-1:0]      io_win_size,
  input logic               io_win_valid,
  input logic [AW-1:0]      mem_win_base,
  input logic [AW-1:0]      mem_win_size,
  input logic               mem_win_valid,
  input logic               lk_hit,
  input logic [AW-1:0]      lk_xlat
);
  // R2
  io_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_upd && ((io_limit_lo < io_base_lo) || (io_limit_hi < io_base_hi))
    |=> !io_win_valid && io_win_size == '0 && io_win_base == '0);

  // R5
  mem_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_upd && (mem_limit_f < mem_base_f)
    |=> !mem_win_valid && mem_win_size == '0 && mem_win_base == '0);

  // R6
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_win_valid |-> mem_win_base[MEM_SH-1:0] == '0 && (&mem_win_size[MEM_SH-1:0]));

  // R7
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_upd |=> $stable(io_win_base) && $stable(io_win_size) && $stable(io_win_valid));

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_upd |=> $stable(mem_win_base) && $stable(mem_win_size) && $stable(mem_win_valid));

  // R8
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_is_io ? io_win_valid : mem_win_valid));

  // R9
  mem_noremap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && !lk_is_io |-> lk_xlat == lk_addr);

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_xlat == '0);
endmodule

bind brwin_decoder brwin_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .io_base_lo(io_base_lo), .io_limit_lo(io_limit_lo),
  .io_base_hi(io_base_hi), .io_limit_hi(io_limit_hi), .io_upd(io_upd),
  .mem_base_f(mem_base_f), .mem_limit_f(mem_limit_f), .mem_upd(mem_upd),
  .lk_addr(lk_addr), .lk_is_io(lk_is_io),
  .io_win_base(io_win_base), .io_win_size(io_win_size), .io_win_valid(io_win_valid),
  .mem_win_base(mem_win_base), .mem_win_size(mem_win_size), .mem_win_valid(mem_win_valid),
  .lk_hit(lk_hit), .lk_xlat(lk_xlat)
);

// File: tb/brwin_decoder_tb.sv
module brwin_decoder_tb;
  // fields: iob(8) iol(8) iobh(16) iolh(16) mb(16) ml(16) ofs(32) exp_io_v(1) exp_mem_v(1)
  localparam int NV = 6;
  localparam logic [113:0] VEC [NV] = '{
    {8'h10, 8'h1F, 16'h0000, 16'h0000, 16'h1000, 16'h1FF0, 32'hC000_0000, 1'b1, 1'b1},
    {8'h21, 8'h21, 16'h0001, 16'h0002, 16'hE000, 16'hE000, 32'h8000_0000, 1'b1, 1'b1},
    {8'h30, 8'h20, 16'h0000, 16'h0000, 16'h2000, 16'h1000, 32'h8000_0000, 1'b0, 1'b0},
    {8'h10, 8'h20, 16'h0003, 16'h0002, 16'h0000, 16'h0000, 32'h4000_0000, 1'b0, 1'b1},
    {8'h21, 8'h20, 16'h0000, 16'h0000, 16'h123F, 16'h1230, 32'h4000_0000, 1'b0, 1'b0},
    {8'h20, 8'h2F, 16'h0004, 16'h0004, 16'h1230, 16'h123F, 32'h0010_0000, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  io_base_lo = '0, io_limit_lo = '0;
  logic [15:0] io_base_hi = '0, io_limit_hi = '0;
  logic        io_upd = 1'b0, mem_upd = 1'b0;
  logic [15:0] mem_base_f = '0, mem_limit_f = '0;
  logic [31:0] io_cpu_ofs = '0, lk_addr = '0;
  logic        lk_is_io = 1'b0;
  logic [31:0] io_win_base, io_win_size, io_win_bus, mem_win_base, mem_win_size, lk_xlat;
  logic        io_win_valid, mem_win_valid, lk_hit;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model of the windows
  logic [31:0] m_io_cpu = '0, m_io_sz = '0, m_io_bus = '0, m_mem_b = '0, m_mem_sz = '0;
  logic        m_io_v = 1'b0, m_mem_v = 1'b0;

  always #5 clk = ~clk;

  brwin_decoder u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_io();
    longint unsigned lo_bus, hi_bus;
    if (int'(io_limit_lo) < int'(io_base_lo) || int'(io_limit_hi) < int'(io_base_hi)) begin
      m_io_v = 0; m_io_cpu = 0; m_io_sz = 0; m_io_bus = 0;
    end else begin
      lo_bus = longint'(io_base_hi) * 65536 + longint'(io_base_lo / 16) * 4096;
      hi_bus = longint'(io_limit_hi) * 65536 + longint'(io_limit_lo / 16) * 4096 + 4095;
      m_io_v = 1; m_io_bus = 32'(lo_bus);
      m_io_cpu = 32'(longint'(io_cpu_ofs) + lo_bus);
      m_io_sz = 32'(hi_bus - lo_bus);
    end
  endtask

  task automatic model_mem();
    longint unsigned b, e;
    if (int'(mem_limit_f) < int'(mem_base_f)) begin
      m_mem_v = 0; m_mem_b = 0; m_mem_sz = 0;
    end else begin
      b = longint'(mem_base_f / 16) * 1048576;
      e = longint'(mem_limit_f / 16) * 1048576 + 1048575;
      m_mem_v = 1; m_mem_b = 32'(b); m_mem_sz = 32'(e - b);
    end
  endtask

  task automatic check_windows(input string tag);
    check({tag, " R2 io valid"}, 32'(io_win_valid), 32'(m_io_v));
    check({tag, " R3 io cpu base"}, io_win_base, m_io_cpu);
    check({tag, " R3 io bus base"}, io_win_bus, m_io_bus);
    check({tag, " R4 io size"}, io_win_size, m_io_sz);
    check({tag, " R5 mem valid"}, 32'(mem_win_valid), 32'(m_mem_v));
    check({tag, " R6 mem base"}, mem_win_base, m_mem_b);
    check({tag, " R6 mem size"}, mem_win_size, m_mem_sz);
  endtask

  task automatic look(input logic [31:0] a, input logic is_io);
    longint unsigned b, s;
    bit eh;
    logic [31:0] ex;
    lk_addr = a; lk_is_io = is_io;
    #1;
    b = is_io ? longint'(m_io_cpu) : longint'(m_mem_b);
    s = is_io ? longint'(m_io_sz) : longint'(m_mem_sz);
    eh = (is_io ? m_io_v : m_mem_v) && longint'(a) >= b && longint'(a) <= b + s;
    ex = !eh ? 32'h0 : (is_io ? 32'(longint'(a) - b + longint'(m_io_bus)) : a);
    check("R8 lookup hit", 32'(lk_hit), 32'(eh));
    check("R9 lookup xlat", lk_xlat, ex);
  endtask

  task automatic probe_edges();
    if (m_io_v) begin
      look(m_io_cpu, 1'b1);
      look(m_io_cpu + m_io_sz, 1'b1);
      look(m_io_cpu + m_io_sz + 1, 1'b1);
      look(m_io_cpu - 1, 1'b1);
    end
    if (m_mem_v) begin
      look(m_mem_b, 1'b0);
      look(m_mem_b + m_mem_sz, 1'b0);
      look(m_mem_b + m_mem_sz + 1, 1'b0);
      look(m_mem_b - 1, 1'b0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_windows("R1 reset");
    look(32'h0, 1'b0);
    look(32'h0, 1'b1);

    // table walk: both strobes per vector (R2..R6, R8, R9)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {io_base_lo, io_limit_lo, io_base_hi, io_limit_hi, mem_base_f, mem_limit_f, io_cpu_ofs} = VEC[i][113:2];
      io_upd = 1'b1; mem_upd = 1'b1;
      model_io(); model_mem();
      @(negedge clk);
      io_upd = 1'b0; mem_upd = 1'b0;
      check($sformatf("vec%0d R2 io valid per table", i), 32'(io_win_valid), 32'(VEC[i][1]));
      check($sformatf("vec%0d R5 mem valid per table", i), 32'(mem_win_valid), 32'(VEC[i][0]));
      check_windows($sformatf("vec%0d", i));
      probe_edges();
    end

    // R7: fields change with no strobe, windows hold
    io_base_lo = 8'h00; io_limit_lo = 8'hF0; mem_base_f = 16'h0000; mem_limit_f = 16'hFFF0;
    io_cpu_ofs = 32'h0;
    repeat (3) @(negedge clk);
    check_windows("R7 hold");

    // R7: memory strobe only, I/O untouched
    mem_base_f = 16'h4000; mem_limit_f = 16'h40F0;
    mem_upd = 1'b1; model_mem();
    @(negedge clk);
    mem_upd = 1'b0;
    check_windows("R7 mem-only strobe");

    // R7: one-cycle latency, nothing visible before the edge
    io_base_lo = 8'h50; io_limit_lo = 8'h50; io_base_hi = 16'h0; io_limit_hi = 16'h0;
    io_cpu_ofs = 32'h1000_0000;
    io_upd = 1'b1;
    #1;
    check("R7 no change before edge", io_win_base, m_io_cpu);
    model_io();
    @(negedge clk);
    io_upd = 1'b0;
    check_windows("R7 io-only strobe");

    // R8: type select, a memory-window address probed as I/O misses
    look(32'h4000_0000, 1'b1);
    look(32'h4000_0000, 1'b0);
    look(32'h1000_5000, 1'b0);
    look(32'h1000_5FFF, 1'b1);

    // R2: drop a valid I/O window through upper-half violation
    @(negedge clk);
    io_base_hi = 16'h0005; io_limit_hi = 16'h0004; io_upd = 1'b1; model_io();
    @(negedge clk);
    io_upd = 1'b0;
    check_windows("R2 drop");
    look(32'h1000_5000, 1'b1);

    finish_run();
  end
endmodule